// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N = B·P + A. It pairs a dual-modulus prescaler, which divides by P or P+1, with two down-counters. The swallow count A sets how many prescaler sub-cycles run at the longer modulus P+1. The main count B sets the total number of sub-cycles in one output period. The prescaler base P is picked by a 2-bit code from the set 8, 16, 32 and 64. All of this is modelled as synchronous logic clocked by the input clock, so it can sit in the feedback path of a frequency synthesizer ahead of a phase comparator.

The divided output is a pulse one input clock wide at the end of each period. The modulus-control output shows which modulus the prescaler is using. New A, B and P values are captured only when a period ends, so a period in progress always completes with the values it started with. Either of two hold inputs (counter reset and power-down) keeps every counter in its load state. When the hold is released, the first period is a complete one. An illegal-configuration flag reports a loaded setting with A greater than B, or with B below 3.

Top module: `swallow_divider`

## Requirements
- R1: With code `psel` (00→P=8, 01→P=16, 10→P=32, 11→P=64) and A ≤ B, consecutive `div_out` pulses are exactly B·P + A input clocks apart.
- R2: `div_out` is high for exactly one input clock per output period and never for two clocks in a row.
- R3: In every period, `mod_ctl` is high for the first A·(P+1) input clocks, counted from the clock in which the period's pulse appears, and low for the rest of the period. While held, it is high exactly when the `a_val` input is nonzero.
- R4: With A = 0, `mod_ctl` stays low and the period is B·P.
- R5: A change of `a_val`, `b_val` or `psel` during a period leaves that period's length unchanged. The new values govern the following periods.
- R6: While `cnt_rst` is high, no pulse is produced and the counters stay loaded. After it is released, the first pulse appears exactly N clocks later.
- R7: `pwr_dn` holds the counters in the same way as `cnt_rst`, and the first period after it is released is a complete N.
- R8: `cfg_bad` is high exactly when the loaded setting has A > B or B < 3. It is updated at each period boundary and continuously while held.
- R9: With A > B, every sub-cycle uses P+1, so the period is B·(P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Counter hold; counters stay at load state while high |
| pwr_dn | input | 1 | Power-down; holds counters like cnt_rst |
| psel | input | 2 | Prescaler code: 00=8/9, 01=16/17, 10=32/33, 11=64/65 |
| a_val | input | 6 | Swallow count A, 0 to 63 |
| b_val | input | 13 | Main count B, 3 to 8191 |
| div_out | output | 1 | One-clock pulse at the end of each output period |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| cfg_bad | output | 1 | Loaded setting has A > B or B < 3 |

## Verification
The scoreboard predicts every period length and the number of clocks with the modulus control high. It covers all four prescaler codes, A = 0, A = B, the largest A with P = 64, and A > B. A divider that lost one count at the reload boundary or kept the long modulus for one sub-cycle too many would show periods off by one or by P. The bench changes the settings in the middle of a period and expects the old length for that period. A design that loaded values immediately would produce a short or mixed period there. Holds of both kinds are applied in the middle of a period, and a complete first period is expected after each release. A design that resumed a partial count would pulse early.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
    // Default field widths and prescaler base modulus
    localparam int SW_A_W    = 6;
    localparam int SW_B_W    = 13;
    localparam int SW_PSEL_W = 2;
    localparam int SW_BASE   = 8;
    // Smallest legal main count
    localparam int SW_B_MIN  = 3;
endpackage

// File: rtl/swdiv_prescaler.sv
// Dual-modulus prescaler model: counts P or P+1 input clocks per sub-cycle.
module swdiv_prescaler #(
    parameter int PSEL_W = swdiv_pkg::SW_PSEL_W,
    parameter int BASE   = swdiv_pkg::SW_BASE,
    localparam int MAX_MOD = (BASE << ((1 << PSEL_W) - 1)) + 1,
    localparam int CNT_W   = $clog2(MAX_MOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [PSEL_W-1:0] psel,
    input  logic              plus,
    output logic              sub_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count is modulus minus one; modulus = BASE*2^psel (+1)
    always_comb begin
        last_cnt = (CNT_W'(BASE) << psel) + CNT_W'(plus) - CNT_W'(1);
        sub_end  = !hold && (st_q.cnt == last_cnt);
        st_d     = st_q;
        if (hold || sub_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/swdiv_sequencer.sv
// Swallow and main counters, configuration capture, output pulse, legality flag.
module swdiv_sequencer #(
    parameter int A_W    = swdiv_pkg::SW_A_W,
    parameter int B_W    = swdiv_pkg::SW_B_W,
    parameter int PSEL_W = swdiv_pkg::SW_PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sub_end,
    input  logic [A_W-1:0]    a_in,
    input  logic [B_W-1:0]    b_in,
    input  logic [PSEL_W-1:0] psel_in,
    output logic [PSEL_W-1:0] psel_act,
    output logic              plus,
    output logic              pulse,
    output logic              bad
);
    localparam logic [B_W-1:0] B_MIN = B_W'(swdiv_pkg::SW_B_MIN);

    typedef struct packed {
        logic [A_W-1:0]    a_left;
        logic [B_W-1:0]    b_left;
        logic [PSEL_W-1:0] psel;
        logic              pulse;
        logic              bad;
    } seq_t;

    seq_t st_d, st_q;
    logic illegal;
    logic last_sub;

    // R8: A above B, or B below the minimum
    assign illegal  = (B_W'(a_in) > b_in) || (b_in < B_MIN);
    // Final sub-cycle of the period (also ends a degenerate zero/one count)
    assign last_sub = (st_q.b_left <= B_W'(1));

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (hold) begin
            // R6 R7: sit at load state
            st_d.a_left = a_in;
            st_d.b_left = b_in;
            st_d.psel   = psel_in;
            st_d.bad    = illegal;
        end else if (sub_end) begin
            if (last_sub) begin
                // R5: settings captured only at the period boundary
                st_d.a_left = a_in;
                st_d.b_left = b_in;
                st_d.psel   = psel_in;
                st_d.bad    = illegal;
                st_d.pulse  = 1'b1;
            end else begin
                st_d.b_left = st_q.b_left - B_W'(1);
                if (st_q.a_left != '0) begin
                    st_d.a_left = st_q.a_left - A_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psel_act = st_q.psel;
    assign plus     = (st_q.a_left != '0);   // R3 R9
    assign pulse    = st_q.pulse;            // R2
    assign bad      = st_q.bad;
endmodule

// File: rtl/swallow_divider.sv
// Top: pulse-swallow feedback divider, N = B*P + A.
module swallow_divider #(
    parameter int A_W    = swdiv_pkg::SW_A_W,
    parameter int B_W    = swdiv_pkg::SW_B_W,
    parameter int PSEL_W = swdiv_pkg::SW_PSEL_W,
    parameter int BASE   = swdiv_pkg::SW_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst,
    input  logic              pwr_dn,
    input  logic [PSEL_W-1:0] psel,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    output logic              div_out,
    output logic              mod_ctl,
    output logic              cfg_bad
);
    logic              hold;
    logic              sub_end;
    logic              plus;
    logic [PSEL_W-1:0] psel_act;

    assign hold = cnt_rst | pwr_dn;

    swdiv_prescaler #(
        .PSEL_W (PSEL_W),
        .BASE   (BASE)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .psel    (psel_act),
        .plus    (plus),
        .sub_end (sub_end)
    );

    swdiv_sequencer #(
        .A_W    (A_W),
        .B_W    (B_W),
        .PSEL_W (PSEL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .sub_end  (sub_end),
        .a_in     (a_val),
        .b_in     (b_val),
        .psel_in  (psel),
        .psel_act (psel_act),
        .plus     (plus),
        .pulse    (div_out),
        .bad      (cfg_bad)
    );

    assign mod_ctl = plus;
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
    parameter int A_W    = swdiv_pkg::SW_A_W,
    parameter int B_W    = swdiv_pkg::SW_B_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cnt_rst,
    input logic           pwr_dn,
    input logic [A_W-1:0] a_val,
    input logic [B_W-1:0] b_val,
    input logic           div_out,
    input logic           mod_ctl,
    input logic           cfg_bad
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out); // R2

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !div_out); // R6

    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !div_out); // R7

    AST_HOLD_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst || pwr_dn) |=> (mod_ctl == ($past(a_val) != '0))); // R3

    AST_HOLD_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst || pwr_dn) |=> (cfg_bad == ((B_W'($past(a_val)) > $past(b_val))
                                             || ($past(b_val) < B_W'(3))))); // R8

    AST_MOD_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> (div_out || $past(cnt_rst || pwr_dn))); // R5

    AST_BAD_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_out && !$past(cnt_rst || pwr_dn)) |-> $stable(cfg_bad)); // R5
endmodule

bind swallow_divider swdiv_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_rst (cnt_rst),
    .pwr_dn  (pwr_dn),
    .a_val   (a_val),
    .b_val   (b_val),
    .div_out (div_out),
    .mod_ctl (mod_ctl),
    .cfg_bad (cfg_bad)
);

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_rst = 1'b1;
    logic        pwr_dn = 1'b0;
    logic [1:0]  psel = 2'd0;
    logic [5:0]  a_val = 6'd0;
    logic [12:0] b_val = 13'd3;
    logic        div_out;
    logic        mod_ctl;
    logic        cfg_bad;

    always #2 clk = ~clk;   // 250 MHz

    swallow_divider u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_rst (cnt_rst),
        .pwr_dn  (pwr_dn),
        .psel    (psel),
        .a_val   (a_val),
        .b_val   (b_val),
        .div_out (div_out),
        .mod_ctl (mod_ctl),
        .cfg_bad (cfg_bad)
    );

    typedef struct {
        int    period;
        int    mod_hi;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   seen = 0;
    int   sample_idx = 0;
    int   ref_idx = 0;
    int   mod_cnt = 0;
    bit   armed = 0;
    bit   prev_div = 0;
    bit   prev_hold = 0;
    bit   done = 0;
    int   cur_a = 5, cur_b = 10, cur_p = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input int a, input int b, input int p, input string tag);
        exp_t e;
        int pm;
        pm = 8 << p;
        if (a <= b) begin
            e.period = b * pm + a;
            e.mod_hi = a * (pm + 1);
        end else begin
            e.period = b * (pm + 1);   // R9
            e.mod_hi = b * (pm + 1);
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic push_exp(input int a, input int b, input int p, input int n, input string tag);
        for (int i = 0; i < n; i++) q.push_back(model(a, b, p, tag));
    endtask

    task automatic set_cfg(input int a, input int b, input int p);
        cur_a = a; cur_b = b; cur_p = p;
        a_val = 6'(a); b_val = 13'(b); psel = 2'(p);
    endtask

    task automatic wait_pulses(input int k);
        int t;
        t = seen + k;
        wait (seen >= t);
        @(posedge clk); #1;
    endtask

    // Change settings mid-period: ongoing period keeps old values (R5)
    task automatic change_cfg(input int a, input int b, input int p, input int n, input string tag);
        push_exp(cur_a, cur_b, cur_p, 1, "R5");
        set_cfg(a, b, p);
        push_exp(a, b, p, n, tag);
        wait_pulses(n + 1);
    endtask

    // Monitor: scoreboard pop on each pulse
    always @(negedge clk) begin
        bit hold_now;
        exp_t e;
        hold_now = cnt_rst | pwr_dn;
        if (rst_n) begin
            if (hold_now) begin
                if (prev_hold && div_out) chk(1'b0, "R6/R7 pulse during hold", 1, 0);
                armed = 0;
            end else begin
                if (!armed) begin
                    armed   = 1;
                    ref_idx = sample_idx;
                    mod_cnt = 0;
                end
                if (div_out) begin
                    if (prev_div) chk(1'b0, "R2 wide pulse", 2, 1);
                    if (q.size() == 0) begin
                        chk(1'b0, "R1 unexpected pulse", 1, 0);
                    end else begin
                        e = q.pop_front();
                        chk((sample_idx - ref_idx) == e.period, {e.tag, " period"},
                            sample_idx - ref_idx, e.period);
                        chk(mod_cnt == e.mod_hi, {e.tag, " R3 modulus-high clocks"},
                            mod_cnt, e.mod_hi);
                    end
                    ref_idx = sample_idx;
                    mod_cnt = 0;
                    seen++;
                end
                if (mod_ctl) mod_cnt++;
            end
        end
        prev_div  = div_out;
        prev_hold = hold_now;
        sample_idx++;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        set_cfg(5, 10, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(div_out == 1'b0, "reset div_out R2", int'(div_out), 0);
        chk(mod_ctl == 1'b0, "reset mod_ctl R3", int'(mod_ctl), 0);
        chk(cfg_bad == 1'b0, "reset cfg_bad R8", int'(cfg_bad), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(div_out == 1'b0, "R6 held output", int'(div_out), 0);
        chk(mod_ctl == 1'b1, "R3 held mod_ctl with A=5", int'(mod_ctl), 1);
        chk(cfg_bad == 1'b0, "R8 legal 5/10", int'(cfg_bad), 0);

        // R1 / R6: release counter reset, full periods
        @(posedge clk); #1;
        push_exp(5, 10, 0, 3, "R1 R6");
        cnt_rst = 1'b0;
        wait_pulses(3);

        change_cfg(0, 7, 1, 2, "R4");
        change_cfg(63, 100, 3, 2, "R1");
        change_cfg(3, 3, 2, 2, "R3");
        @(negedge clk);
        chk(cfg_bad == 1'b0, "R8 legal A=B", int'(cfg_bad), 0);
        @(posedge clk); #1;
        change_cfg(9, 4, 0, 2, "R9");
        @(negedge clk);
        chk(cfg_bad == 1'b1, "R8 A>B flagged", int'(cfg_bad), 1);

        // R7: power-down mid-period, new settings during the hold
        repeat (5) @(posedge clk);
        #1 pwr_dn = 1'b1;
        set_cfg(2, 5, 0);
        repeat (40) @(negedge clk);
        chk(div_out == 1'b0, "R7 no pulse in power-down", int'(div_out), 0);
        chk(mod_ctl == 1'b1, "R7 held mod_ctl A=2", int'(mod_ctl), 1);
        chk(cfg_bad == 1'b0, "R8 cleared during hold", int'(cfg_bad), 0);
        @(posedge clk); #1;
        push_exp(2, 5, 0, 2, "R7");
        pwr_dn = 1'b0;
        wait_pulses(2);

        // R6: counter reset mid-period with illegal B
        repeat (7) @(posedge clk);
        #1 cnt_rst = 1'b1;
        set_cfg(1, 2, 0);
        repeat (10) @(negedge clk);
        chk(cfg_bad == 1'b1, "R8 B below 3", int'(cfg_bad), 1);
        @(posedge clk); #1;
        set_cfg(1, 3, 1);
        repeat (5) @(negedge clk);
        chk(cfg_bad == 1'b0, "R8 legal 1/3", int'(cfg_bad), 0);
        chk(div_out == 1'b0, "R6 no pulse in counter reset", int'(div_out), 0);
        @(posedge clk); #1;
        push_exp(1, 3, 1, 2, "R6");
        cnt_rst = 1'b0;
        wait_pulses(2);

        chk(q.size() == 0, "R1 all expected periods seen", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule